// File: doc/BRIEF.md
# PWM Output Emergency Disable Controller

This block protects the power stage behind a complementary PWM timer. It watches three complementary output pairs and four active-low shutdown request inputs. When a fault appears it drops the output enables of a group of pins, so the pad logic can place those pins in high impedance. There are two kinds of fault. The first is an external request. The second is a short-circuit condition, where both pins of a monitored pair sit at their active level in the same clock cycle.

Three of the request inputs act on all six complementary pins. The fourth acts only on the three pins of a separate single-channel timer group. Each fault source latches a sticky flag. The enables stay low until software clears that flag, and software can only clear it once the fault condition has gone. The active level of each pair comes from one of two settings, picked by a select bit. One setting is a global positive/negative level pair. The other is a per-phase set of levels. A combined flag output can serve as an interrupt request.

Top module: `pwm_shutdown_ctrl`

## Requirements
- R1: While any of the flags for request inputs 0, 1 or 2 is set, all six complementary enables (`comp_oe`) are 0. The single-group enables (`single_oe`) are not affected by these flags.
- R2: While the flag for request input 3 is set, all three `single_oe` bits are 0. This flag alone leaves `comp_oe` at all ones.
- R3: A request input is first passed through a two-stage synchronizer. It counts as asserted once its synchronized value has been low on three consecutive clock edges. If the input is driven low before rising edge 1, its flag becomes visible after rising edge 6. A low pulse that is captured on only two edges sets no flag.
- R4: Pairs are indexed k = 0 (phase-3 B/D), 1 (phase-4 A/C) and 2 (phase-4 B/D). The positive pin of pair k is `pair_pos[k]` and its enable is `comp_oe[2k]`. The negative pin is `pair_neg[k]` and its enable is `comp_oe[2k+1]`. If an enabled pair has both pins at their active level when a rising edge samples them, short flag k is set after that edge and all of `comp_oe` go to 0.
- R5: A pair whose compare-enable bit (CTRL[k]) is 0 never sets its short flag, whatever its pin levels.
- R6: When CTRL[3] (level select) is 0, CTRL[4] gives the active level of every positive pin and CTRL[5] gives the active level of every negative pin. A value of 1 means active high and 0 means active low.
- R7: When CTRL[3] is 1, the level register LVL sets the active level per pair: LVL[2k] for the positive pin of pair k and LVL[2k+1] for its negative pin. A value of 1 means active high.
- R8: Flags are sticky. Writing 1 to a bit of FLAG clears that flag, unless the condition that sets it is present in the same cycle, in which case the clear has no effect. FLAG[3:0] holds the flags for request inputs 0 to 3, and FLAG[6:4] holds the short flags for pairs 0 to 2.
- R9: After reset every enable output is 1, every flag is 0, `fault_irq` is 0, and CTRL and LVL read as 0, so compare is disabled on all pairs.
- R10: `fault_irq` is 1 exactly when at least one flag is set.
- R11: The register map is CTRL at address 0, LVL at address 1 and FLAG at address 2. CTRL and LVL read back the byte last written. Address 3 reads 0. The read path is combinational from `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low shutdown requests; bits 0-2 act on the complementary group, bit 3 on the single group |
| pair_pos | input | 3 | Observed level of the positive pin of each monitored pair |
| pair_neg | input | 3 | Observed level of the negative pin of each monitored pair |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| comp_oe | output | 6 | Output enables of the complementary pins (0 = high impedance) |
| single_oe | output | 3 | Output enables of the single-group pins (0 = high impedance) |
| fault_irq | output | 1 | Any flag set |

## Verification
The assertions check the following on every cycle:
- A complementary request flag or a qualified short always removes the complementary enables.
- The single-group request acts only on its own pins.
- A disabled pair never reports a short.
- A flag never drops without a clear.
- A still-present condition keeps its flag set.

The bench scenarios cover what the assertions cannot:
- The exact edge on which a request qualifies.
- The rejection of short pulses.
- The mapping of every level setting to pin values, swept over all pin combinations in both level modes.
- The register readback.

// File: rtl/pwm_shutdown_pkg.sv
package pwm_shutdown_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LVL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

  // A pin is at its active level when it equals the configured level bit.
  function automatic logic pin_at_active(input logic pin, input logic act_hi);
    return pin == act_hi;
  endfunction

  // Returns {neg_level, pos_level} for one pair.
  function automatic logic [1:0] pick_levels(input logic sel_phase,
                                             input logic glob_p, input logic glob_n,
                                             input logic ph_p, input logic ph_n);
    return sel_phase ? {ph_n, ph_p} : {glob_n, glob_p};
  endfunction

  function automatic logic pair_shorted(input logic en, input logic p, input logic n,
                                        input logic [1:0] lvl);
    return en && pin_at_active(p, lvl[0]) && pin_at_active(n, lvl[1]);
  endfunction
endpackage

// File: rtl/pwm_sd_req_qual.sv
module pwm_sd_req_qual #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic req_det
);
  logic [SYNC_STAGES-1:0]  sync_q;
  logic [QUAL_SAMPLES-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_n};
      hist_q <= {hist_q[QUAL_SAMPLES-2:0], sync_q[SYNC_STAGES-1]};
    end
  end

  // asserted once every retained synchronized sample is low
  assign req_det = ~|hist_q;
endmodule

// File: rtl/pwm_sd_pair_mon.sv
module pwm_sd_pair_mon
  import pwm_shutdown_pkg::*;
#(
  parameter int NUM_PAIRS = 3
) (
  input  logic [NUM_PAIRS-1:0]   pair_pos,
  input  logic [NUM_PAIRS-1:0]   pair_neg,
  input  logic [NUM_PAIRS-1:0]   cmp_en,
  input  logic                   sel_phase,
  input  logic                   glob_p,
  input  logic                   glob_n,
  input  logic [2*NUM_PAIRS-1:0] phase_lvl,
  output logic [NUM_PAIRS-1:0]   short_det
);
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic [1:0] lvl;
    assign lvl = pick_levels(sel_phase, glob_p, glob_n, phase_lvl[2*k], phase_lvl[2*k+1]);
    assign short_det[k] = pair_shorted(cmp_en[k], pair_pos[k], pair_neg[k], lvl);
  end
endmodule

// File: rtl/pwm_sd_regs.sv
module pwm_sd_regs
  import pwm_shutdown_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int NUM_REQ   = 4,
  parameter int DATA_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  input  logic [NUM_REQ-1:0]     req_det,
  input  logic [NUM_PAIRS-1:0]   short_det,
  output logic [NUM_PAIRS-1:0]   cmp_en,
  output logic                   sel_phase,
  output logic                   glob_p,
  output logic                   glob_n,
  output logic [2*NUM_PAIRS-1:0] phase_lvl,
  output logic [NUM_REQ+NUM_PAIRS-1:0] flags,
  output logic [NUM_REQ+NUM_PAIRS-1:0] clr_vec
);
  localparam int FLAG_W  = NUM_REQ + NUM_PAIRS;
  localparam int SEL_BIT = NUM_PAIRS;
  localparam int GP_BIT  = NUM_PAIRS + 1;
  localparam int GN_BIT  = NUM_PAIRS + 2;

  logic [DATA_W-1:0] ctrl_q, lvl_q;
  logic [FLAG_W-1:0] flags_q, set_vec;

  assign set_vec = {short_det, req_det};
  assign clr_vec = (wr_en && wr_addr == ADDR_FLAG) ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lvl_q   <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data;
      if (wr_en && wr_addr == ADDR_LVL)  lvl_q  <= wr_data;
      // a present condition wins over a clear
      flags_q <= set_vec | (flags_q & ~clr_vec);
    end
  end

  assign cmp_en    = ctrl_q[NUM_PAIRS-1:0];
  assign sel_phase = ctrl_q[SEL_BIT];
  assign glob_p    = ctrl_q[GP_BIT];
  assign glob_n    = ctrl_q[GN_BIT];
  assign phase_lvl = lvl_q[2*NUM_PAIRS-1:0];
  assign flags     = flags_q;

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_q;
      ADDR_LVL:  rd_data = lvl_q;
      ADDR_FLAG: rd_data = {{(DATA_W-FLAG_W){1'b0}}, flags_q};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_shutdown_ctrl.sv
module pwm_shutdown_ctrl
  import pwm_shutdown_pkg::*;
#(
  parameter int NUM_PAIRS    = 3,
  parameter int NUM_COMP_REQ = 3,
  parameter int SINGLE_PINS  = 3,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_COMP_REQ:0]     req_n,
  input  logic [NUM_PAIRS-1:0]      pair_pos,
  input  logic [NUM_PAIRS-1:0]      pair_neg,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [1:0]                rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [2*NUM_PAIRS-1:0]    comp_oe,
  output logic [SINGLE_PINS-1:0]    single_oe,
  output logic                      fault_irq
);
  localparam int NUM_REQ = NUM_COMP_REQ + 1;
  localparam int FLAG_W  = NUM_REQ + NUM_PAIRS;

  logic [NUM_REQ-1:0]     req_det;
  logic [NUM_PAIRS-1:0]   short_det;
  logic [NUM_PAIRS-1:0]   cmp_en;
  logic                   sel_phase, glob_p, glob_n;
  logic [2*NUM_PAIRS-1:0] phase_lvl;
  logic [FLAG_W-1:0]      flags, clr_vec;
  logic                   comp_fault, single_fault;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    pwm_sd_req_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_SAMPLES(QUAL_SAMPLES)) u_qual (
      .clk(clk), .rst_n(rst_n), .req_n(req_n[i]), .req_det(req_det[i]));
  end

  pwm_sd_pair_mon #(.NUM_PAIRS(NUM_PAIRS)) u_mon (
    .pair_pos(pair_pos), .pair_neg(pair_neg), .cmp_en(cmp_en), .sel_phase(sel_phase),
    .glob_p(glob_p), .glob_n(glob_n), .phase_lvl(phase_lvl), .short_det(short_det));

  pwm_sd_regs #(.NUM_PAIRS(NUM_PAIRS), .NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_det(req_det), .short_det(short_det),
    .cmp_en(cmp_en), .sel_phase(sel_phase), .glob_p(glob_p), .glob_n(glob_n),
    .phase_lvl(phase_lvl), .flags(flags), .clr_vec(clr_vec));

  // high impedance takes effect in the cycle the flag sets
  assign comp_fault   = |flags[NUM_COMP_REQ-1:0] | |flags[FLAG_W-1:NUM_REQ];
  assign single_fault = flags[NUM_COMP_REQ];
  assign comp_oe      = {(2*NUM_PAIRS){~comp_fault}};
  assign single_oe    = {SINGLE_PINS{~single_fault}};
  assign fault_irq    = |flags;
endmodule

// File: rtl/pwm_shutdown_ctrl_chk.sv
module pwm_shutdown_ctrl_chk #(
  parameter int NUM_PAIRS    = 3,
  parameter int NUM_COMP_REQ = 3,
  parameter int SINGLE_PINS  = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_COMP_REQ:0]             req_det,
  input logic [NUM_PAIRS-1:0]              short_det,
  input logic [NUM_PAIRS-1:0]              cmp_en,
  input logic [NUM_COMP_REQ+1+NUM_PAIRS-1:0] flags,
  input logic [NUM_COMP_REQ+1+NUM_PAIRS-1:0] clr_vec,
  input logic [2*NUM_PAIRS-1:0]            comp_oe,
  input logic [SINGLE_PINS-1:0]            single_oe,
  input logic                              fault_irq
);
  localparam int NUM_REQ = NUM_COMP_REQ + 1;
  localparam int FLAG_W  = NUM_REQ + NUM_PAIRS;

  AST_COMP_REQ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    |flags[NUM_COMP_REQ-1:0] |-> comp_oe == '0); // R1

  AST_SINGLE_REQ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    req_det[NUM_COMP_REQ] |=> single_oe == '0); // R2

  AST_SINGLE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == FLAG_W'(1) << NUM_COMP_REQ) |-> comp_oe == '1); // R2

  AST_SHORT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    |short_det |=> comp_oe == '0); // R4

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_det || |short_det) |=> fault_irq); // R10

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair_chk
    AST_CMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en[k] |-> !short_det[k]); // R5
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !clr_vec[i] |=> flags[i]); // R8
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req_chk
    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      req_det[i] |=> flags[i]); // R8
  end
endmodule

bind pwm_shutdown_ctrl pwm_shutdown_ctrl_chk #(
  .NUM_PAIRS(NUM_PAIRS), .NUM_COMP_REQ(NUM_COMP_REQ), .SINGLE_PINS(SINGLE_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_det(req_det), .short_det(short_det), .cmp_en(cmp_en),
  .flags(flags), .clr_vec(clr_vec), .comp_oe(comp_oe), .single_oe(single_oe),
  .fault_irq(fault_irq)
);

// File: tb/test_pwm_shutdown_ctrl.sv
module test_pwm_shutdown_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic [2:0] pair_pos = '0, pair_neg = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = 2'd2;
  logic [7:0] rd_data;
  logic [5:0] comp_oe;
  logic [2:0] single_oe;
  logic       fault_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shutdown_ctrl i_pwm_shutdown_ctrl (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .pair_pos(pair_pos), .pair_neg(pair_neg),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .comp_oe(comp_oe), .single_oe(single_oe), .fault_irq(fault_irq));

  task automatic step(input int n = 1);
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
    rd_addr = 2'd2;
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // exercises one request input end to end
  task automatic req_case(input int i);
    logic [7:0] f;
    req_n[i] = 1'b0;
    step(2);
    req_n[i] = 1'b1;
    step(8);
    rd(2'd2, f);
    chk("R3 two-edge pulse ignored", f, 8'h00);
    req_n[i] = 1'b0;
    step(5);
    rd(2'd2, f);
    chk("R3 not yet qualified after 5 edges", f, 8'h00);
    step();
    rd(2'd2, f);
    chk("R3 qualified after 6 edges", f, 8'h01 << i);
    if (i < 3) begin
      chk("R1 comp pins disabled", comp_oe, 6'h00);
      chk("R1 single pins untouched", single_oe, 3'h7);
    end else begin
      chk("R2 single pins disabled", single_oe, 3'h0);
      chk("R2 comp pins untouched", comp_oe, 6'h3F);
    end
    chk("R10 irq on request", fault_irq, 1'b1);
    wr(2'd2, 8'h01 << i);
    rd(2'd2, f);
    chk("R8 clear ignored while request present", f, 8'h01 << i);
    req_n[i] = 1'b1;
    step(4);
    rd(2'd2, f);
    chk("R8 flag sticky after release", f, 8'h01 << i);
    wr(2'd2, 8'h01 << i);
    rd(2'd2, f);
    chk("R8 cleared", f, 8'h00);
    chk("R8 enables restored", {comp_oe, single_oe}, 9'h1FF);
    chk("R10 irq low after clear", fault_irq, 1'b0);
  endtask

  // one short-detector trial: prepare safely, clear, enable, drive pins, check
  task automatic short_trial(input logic [7:0] ctrl, input logic [5:0] lvl,
                             input logic [5:0] pins, input string tag);
    logic [2:0] act_p, act_n, en, exp;
    logic [7:0] f;
    en = ctrl[2:0];
    for (int k = 0; k < 3; k++) begin
      act_p[k] = ctrl[3] ? lvl[2*k]   : ctrl[4];
      act_n[k] = ctrl[3] ? lvl[2*k+1] : ctrl[5];
    end
    wr(2'd0, {ctrl[7:3], 3'b000});
    pair_pos = ~act_p;
    pair_neg = ~act_n;
    wr(2'd2, 8'h70);
    wr(2'd0, ctrl);
    pair_pos = pins[2:0];
    pair_neg = pins[5:3];
    step();
    for (int k = 0; k < 3; k++)
      exp[k] = en[k] && (pins[k] == act_p[k]) && (pins[k+3] == act_n[k]);
    rd(2'd2, f);
    chk({tag, " short flags"}, f, {1'b0, exp, 4'b0000});
    chk("R4 comp enables", comp_oe, (exp != 0) ? 6'h00 : 6'h3F);
    chk("R10 irq follows short", fault_irq, exp != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    step(3);
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk("R9 comp_oe reset", comp_oe, 6'h3F);
    chk("R9 single_oe reset", single_oe, 3'h7);
    chk("R9 irq reset", fault_irq, 1'b0);
    rd(2'd0, d); chk("R9 CTRL reset", d, 8'h00);
    rd(2'd1, d); chk("R9 LVL reset", d, 8'h00);
    rd(2'd2, d); chk("R9 FLAG reset", d, 8'h00);
    // pins at active-low levels with compare disabled after reset: no short (R5)
    step(2);
    rd(2'd2, d); chk("R5 disabled after reset", d, 8'h00);

    // R11 register readback
    wr(2'd0, 8'hF8); rd(2'd0, d); chk("R11 CTRL readback", d, 8'hF8);
    wr(2'd1, 8'hD5); rd(2'd1, d); chk("R11 LVL readback", d, 8'hD5);
    rd(2'd3, d); chk("R11 unused address", d, 8'h00);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    for (int i = 0; i < 4; i++) req_case(i);

    // R6 global levels: all level pairs, all enable masks, all pin patterns
    for (int lv = 0; lv < 4; lv++)
      for (int en = 0; en < 8; en++)
        for (int p = 0; p < 64; p++)
          short_trial({2'b00, lv[1:0], 1'b0, en[2:0]}, 6'h00, p[5:0], "R4 R5 R6");

    // R7 per-phase levels: all level settings, all pin patterns
    for (int pl = 0; pl < 64; pl++) begin
      wr(2'd0, 8'h00);
      wr(2'd1, {2'b00, pl[5:0]});
      for (int p = 0; p < 64; p++)
        short_trial(8'h0F, pl[5:0], p[5:0], "R4 R7");
    end

    // R8 clear ignored while a short persists
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    pair_pos = 3'b111; pair_neg = 3'b111;
    wr(2'd2, 8'h70);
    wr(2'd0, 8'h01);
    pair_pos = 3'b000; pair_neg = 3'b000;
    step();
    wr(2'd2, 8'h10);
    rd(2'd2, d); chk("R8 short clear ignored while present", d, 8'h10);
    pair_pos = 3'b111;
    step();
    wr(2'd2, 8'h10);
    rd(2'd2, d); chk("R8 short clear after removal", d, 8'h00);

    finish_run();
  end
endmodule